// File: doc/BRIEF.md
# Stick-Parity Serial Transmitter

This block serialises one byte at a time onto an asynchronous line. The frame is a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Every bit is held for a fixed number of baud-rate ticks. The tick is an input strobe from a divider outside the block, so the block never sees the divisor itself.

An 8-bit line configuration input selects the frame options. It turns parity on or off and chooses between odd and even parity. A stick option forces the parity bit to a constant mark or space. A break option pulls the line low at once, whatever the transmitter is doing. Only bits 3 to 6 of the configuration are decoded; the other bits are ignored.

Bytes enter through a valid/ready handshake. `in_ready` is high exactly when the transmitter is idle, and a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and `in_data` until that edge. The block does not buffer a second byte. A strobe that arrives while a frame is on the line is dropped, and the producer sees this as back-pressure through `in_ready` being low.

Top module: `stick_uart_tx`

## Requirements
- R1: After reset and between frames, `ser_out` is 1, `busy` is 0 and `in_ready` is 1, provided the break bit (line_cfg[6]) is 0.
- R2: An accepted frame is sent in this order: a 0 start bit, the data bits from bit 0 up to bit 7, and a 1 stop bit. Each bit lasts TICKS_PER_BIT baud ticks. The start bit appears on the cycle after the accepting edge. `busy` falls on the edge that ends the stop bit.
- R3: When line_cfg[3] is 0, no parity bit is sent: the stop bit follows data bit 7 directly. This holds whatever line_cfg[4] and line_cfg[5] are.
- R4: When line_cfg[3]=1, line_cfg[4]=0 and line_cfg[5]=0, a parity bit follows bit 7. It makes the number of ones in the data and parity bits together odd.
- R5: When line_cfg[3]=1, line_cfg[4]=1 and line_cfg[5]=0, the parity bit makes the number of ones in the data and parity bits together even.
- R6: When line_cfg[3]=1, line_cfg[5]=1 and line_cfg[4]=0, the parity bit is always 1 (mark).
- R7: When line_cfg[3], line_cfg[4] and line_cfg[5] are all 1, the parity bit is always 0 (space).
- R8: While line_cfg[6] is 1, `ser_out` is 0 in the same cycle. Break does not start a frame. A frame in progress keeps advancing during break. When the bit is cleared, the line shows the bit the frame has reached at that point.
- R9: `in_ready` equals the inverse of `busy`, and `busy` rises on the cycle after an accept. A strobe while busy is ignored: the frame on the line is unchanged and no further frame follows it.
- R10: The parity options (line_cfg[5:3]) are sampled at the accepting edge. Changing them during a frame does not alter that frame.
- R11: The bit timing advances only on cycles where `baud_tick` is 1. With ticks spaced N cycles apart, a frame takes about N times as long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at the oversampled baud rate |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Transmitter can take a byte this cycle |
| line_cfg | input | 8 | Configuration: [3] parity on, [4] even select, [5] stick, [6] break |
| ser_out | output | 1 | Serial line |
| busy | output | 1 | A frame is being sent |

## Verification
The bench builds the block with its defaults: DATA_W=8 and TICKS_PER_BIT=16. It holds `baud_tick` high for most runs, so each bit lasts exactly 16 cycles and every mid-bit sample falls at a known cycle. One run spaces the ticks three cycles apart, which checks that the timing counts ticks rather than clocks. The directed runs reach the state-dependent cases: break raised and released in the middle of a data bit, a parity option changed during a frame, and a strobe dropped during a frame.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } stx_state_e;

  // positions decoded in the configuration byte
  localparam int CFG_PAR_ON = 3;
  localparam int CFG_EVEN   = 4;
  localparam int CFG_STICK  = 5;
  localparam int CFG_BREAK  = 6;
endpackage

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_done
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_done = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || bit_done) cnt_q <= '0;
    else if (tick)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stx_parity.sv
module stx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              even_sel,
  input  logic              stick,
  output logic              par_bit
);
  logic ones_odd;
  logic normal_bit;

  assign ones_odd   = ^data;
  // even: parity copies the data's oddness; odd: parity inverts it
  assign normal_bit = even_sel ? ones_odd : ~ones_odd;
  // stick: even select gives space (0), odd select gives mark (1)
  assign par_bit    = stick ? ~even_sel : normal_bit;
endmodule

// File: rtl/stx_frame_fsm.sv
module stx_frame_fsm
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              bit_done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_on_in,
  input  logic              par_bit_in,
  output logic              line_bit,
  output logic              busy
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  stx_state_e        state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_on_q;
  logic              par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      idx_q    <= '0;
      par_on_q <= 1'b0;
      par_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_START;
          shreg_q  <= data_in;
          par_on_q <= par_on_in;
          par_q    <= par_bit_in;
        end
        ST_START: if (bit_done) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: if (bit_done) begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= par_on_q ? ST_PAR : ST_STOP;
        end
        ST_PAR:  if (bit_done) state_q <= ST_STOP;
        ST_STOP: if (bit_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/stick_uart_tx.sv
module stick_uart_tx
  import stx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [7:0]        line_cfg,
  output logic              ser_out,
  output logic              busy
);
  logic accept;
  logic bit_done;
  logic par_bit;
  logic line_bit;
  logic cfg_unused;

  assign cfg_unused = ^{line_cfg[7], line_cfg[2:0]};
  assign in_ready   = !busy;
  assign accept     = in_valid && in_ready;

  stx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .tick     (baud_tick),
    .bit_done (bit_done)
  );

  stx_parity #(.DATA_W(DATA_W)) u_par (
    .data     (in_data),
    .even_sel (line_cfg[CFG_EVEN]),
    .stick    (line_cfg[CFG_STICK]),
    .par_bit  (par_bit)
  );

  stx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .bit_done   (bit_done),
    .data_in    (in_data),
    .par_on_in  (line_cfg[CFG_PAR_ON]),
    .par_bit_in (par_bit),
    .line_bit   (line_bit),
    .busy       (busy)
  );

  assign ser_out = line_cfg[CFG_BREAK] ? 1'b0 : line_bit;
endmodule

// File: rtl/stick_uart_tx_chk.sv
module stick_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic brk,
  input logic ser_out,
  input logic busy
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> ser_out);

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !brk) |-> !ser_out);

  // R2
  stop_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(brk)) |-> $past(ser_out));

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !ser_out);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(baud_tick) && $stable(brk)) |-> ($stable(ser_out) && busy));
endmodule

bind stick_uart_tx stick_uart_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .brk       (line_cfg[6]),
  .ser_out   (ser_out),
  .busy      (busy)
);

// File: tb/tb_stick_uart_tx.sv
`timescale 1ns/1ps
module tb_stick_uart_tx;
  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic [7:0] line_cfg = 8'h00;
  logic       ser_out;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tick_ph = 0;

  always #2.5 clk = ~clk;

  stick_uart_tx #(.DATA_W(8), .TICKS_PER_BIT(TPB)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .line_cfg(line_cfg),
    .ser_out(ser_out), .busy(busy)
  );

  always @(negedge clk) begin
    tick_ph   = (tick_ph + 1) % tick_div;
    baud_tick = (tick_div == 1) ? 1'b1 : (tick_ph == 0);
  end

  // {data, cfg, has_parity, parity_bit}
  localparam logic [17:0] VEC [9] = '{
    {8'h55, 8'h00, 1'b0, 1'b0},  // R3 no parity
    {8'h55, 8'h08, 1'b1, 1'b1},  // R4 odd, 4 ones
    {8'h55, 8'h18, 1'b1, 1'b0},  // R5 even, 4 ones
    {8'h07, 8'h08, 1'b1, 1'b0},  // R4 odd, 3 ones
    {8'h07, 8'h18, 1'b1, 1'b1},  // R5 even, 3 ones
    {8'h00, 8'h28, 1'b1, 1'b1},  // R6 mark
    {8'hFF, 8'h38, 1'b1, 1'b0},  // R7 space
    {8'hA3, 8'h30, 1'b0, 1'b0},  // R3 stick without enable
    {8'h80, 8'h08, 1'b1, 1'b0}   // R4 odd, 1 one
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // c counts negedges after the accepting edge; mid-bit k is at c = 16k+8
  task automatic frame_run(input logic [7:0] d, input logic [7:0] cfg, input logic has_p,
                           input logic p, input logic [7:0] cfg_mid, input int brk_on,
                           input int brk_off, input int junk_at, input string tag);
    logic [11:0] bits;
    int nb;
    logic brk_now;
    bits = {2'b11, p, d, 1'b0};
    nb = has_p ? 11 : 10;
    if (!has_p) bits[9] = 1'b1;
    brk_now = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; line_cfg = cfg;
    @(posedge clk);
    for (int c = 0; c < TPB * nb; c++) begin
      @(negedge clk);
      if (c == 0) in_valid = 1'b0;
      if (c == 1) line_cfg = cfg_mid;
      if (c == junk_at) begin in_valid = 1'b1; in_data = ~d; end
      if (c == junk_at + 3) in_valid = 1'b0;
      if (c == brk_on) begin line_cfg[6] = 1'b1; brk_now = 1'b1; end
      if (c == brk_off) begin line_cfg[6] = 1'b0; brk_now = 1'b0; end
      #1;
      if (c % TPB == TPB / 2) begin
        chk(ser_out, brk_now ? 1'b0 : bits[c / TPB], $sformatf("%s bit %0d", tag, c / TPB));
        chk({busy, in_ready}, 2'b10, $sformatf("R9 %s busy/ready in bit %0d", tag, c / TPB));
      end
    end
    @(negedge clk);
    chk({busy, in_ready, ser_out}, 3'b011, {"R1 R2 ", tag, " end of frame"});
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) begin
        chk(busy, 1'b0, {"R9 ", tag, " no extra frame"});
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk({ser_out, busy, in_ready}, 3'b101, "R1 during reset");
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ser_out, busy, in_ready}, 3'b101, "R1 after reset");

    for (int v = 0; v < 9; v++) begin
      frame_run(VEC[v][17:10], VEC[v][9:2], VEC[v][1], VEC[v][0], VEC[v][9:2],
                -1, -1, -10, $sformatf("R2-vec%0d(R3/R4/R5/R6/R7)", v));
    end

    // R8 break while idle
    @(negedge clk) line_cfg = 8'h40;
    #1 chk(ser_out, 1'b0, "R8 break in idle");
    repeat (5) @(negedge clk);
    chk({busy, ser_out}, 2'b00, "R8 break starts no frame");
    line_cfg = 8'h00;
    #1 chk(ser_out, 1'b1, "R8 release in idle");

    // R8 break mid-frame: on in data bit 2, off inside it; later bits normal
    frame_run(8'h0F, 8'h00, 1'b0, 1'b0, 8'h00, 3 * TPB + 4, 3 * TPB + 10, -10, "R8 mid break");
    // R8 break spanning bit samples, released during data bit 5
    frame_run(8'h3C, 8'h00, 1'b0, 1'b0, 8'h00, 2 * TPB + 2, 6 * TPB + 2, -10, "R8 long break");

    // R9 strobe while busy ignored
    frame_run(8'h55, 8'h00, 1'b0, 1'b0, 8'h00, -1, -1, 30, "R9 ignored strobe");

    // R10 cfg changed mid-frame: odd 0x55 -> 1, then switched to even/stick
    frame_run(8'h55, 8'h08, 1'b1, 1'b1, 8'h38, -1, -1, -10, "R10 latched parity");
    frame_run(8'h07, 8'h18, 1'b1, 1'b1, 8'h00, -1, -1, -10, "R10 latched enable");

    // R11 ticks every third cycle
    begin
      int cnt;
      tick_div = 3;
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h5A; line_cfg = 8'h00;
      @(posedge clk);
      cnt = 0;
      @(negedge clk) in_valid = 1'b0;
      while (busy && cnt < 2000) begin
        cnt++;
        @(negedge clk);
      end
      chk((cnt >= 478 && cnt <= 480), 1'b1, $sformatf("R11 sparse ticks frame length %0d", cnt));
      chk(ser_out, 1'b1, "R11 line idle after sparse frame");
      tick_div = 1;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule